// File: doc/BRIEF.md
# ISA-to-IDE Host Adapter Logic

This block is the glue between a 16-bit AT-style ISA I/O bus and one IDE channel. All task-file registers live in the drive, so the adapter has three jobs. It recognises host I/O accesses to the primary command block (1F0h to 1F7h) and to the device control register (3F6h). It turns each such access into the drive's chip selects, the three register address lines, and the read and write strobes. It steers data between the host bus and the 16-bit drive bus. The 16-bit data port at 1F0h is announced to the host as a word transfer. Every other register moves one byte on the low lane.

All decoding is gated by the DMA address-enable signal. During DMA, the bus carries a memory address while an I/O command line is active, and the adapter must stay silent. Port 3F7h is left unclaimed.

On reads, a drive-present input tells the adapter whether a drive is driving the bus. When no drive is present, the adapter returns the weak pull-down value: bit 7 low and all other bits high. A status poll of an empty channel therefore reads 7Fh, not a permanently busy 0FFh. The drive interrupt is routed to one of several host IRQ lines, chosen by a select input.

The ISA command inputs are sampled on the adapter clock. Every drive-side output and the IRQ lines are registered.

Top module: `isa_ide_adapter`

## Requirements
- R1: While reset is held, both chip selects, both drive strobes and the 16-bit indicator are inactive (high), and the register address lines, all host data lane enables, the drive data enable and all IRQ lines are 0.
- R2: An access to 1F0h..1F7h with address enable low and exactly one of the I/O command lines active gives the following one clock edge later: command-block select low, and register address lines equal to host address bits 2..0.
- R3: An access to 3F6h under the same conditions gives the following one edge later: control select low, and register address lines 110b.
- R4: While address enable is high, no chip select, strobe, 16-bit indicator, host data lane enable or drive data enable is asserted, whatever the address and command lines carry.
- R5: Port 3F7h, and any address outside 1F0h..1F7h and 3F6h, asserts no chip select, strobe or data enable.
- R6: The drive read strobe follows a decoded host read, and the drive write strobe follows a decoded host write. When both host command lines are active together, the access is treated as no access.
- R7: The 16-bit indicator is asserted only for a decoded access to 1F0h. Only then is the upper host lane enable (bit 1) set. Every other decoded read enables only lane bit 0.
- R8: On a decoded write, the drive data enable is high and the drive data bus carries the host data word that was sampled at the same edge.
- R9: On a decoded read with a drive present, the host data output equals the drive data input.
- R10: On a decoded read with no drive present, the host data output is 0xFF7F: bit 7 is 0 and all other bits are 1, so a byte read gives 7Fh.
- R11: One edge after the drive interrupt is sampled, the IRQ line indexed by the select input equals it, and all other IRQ lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Adapter clock |
| rstN | input | 1 | Active-low synchronous reset |
| isaAddr | input | 10 | Host I/O address bits 9..0 |
| isaAen | input | 1 | Address enable, high during DMA cycles |
| isaIorN | input | 1 | Host I/O read command, active low |
| isaIowN | input | 1 | Host I/O write command, active low |
| isaDataIn | input | 16 | Host write data |
| isaDataOut | output | 16 | Read data returned to host |
| isaLaneOe | output | 2 | Host data lane drive enables (bit 0 low byte, bit 1 high byte) |
| isaIocs16N | output | 1 | 16-bit transfer indicator, active low |
| isaIrq | output | 4 | Host interrupt request lines |
| irqSel | input | 2 | Index of the IRQ line that carries the drive interrupt |
| ideCs0N | output | 1 | Command-block chip select, active low |
| ideCs1N | output | 1 | Control-block chip select, active low |
| ideDa | output | 3 | Drive register address |
| ideDiorN | output | 1 | Drive read strobe, active low |
| ideDiowN | output | 1 | Drive write strobe, active low |
| ideDataOut | output | 16 | Write data to drive |
| ideDataOe | output | 1 | Drive data bus enable for writes |
| ideDataIn | input | 16 | Data driven by the drive |
| drivePresent | input | 1 | High when a drive is driving the data bus |
| ideIntrq | input | 1 | Drive interrupt request |

## Verification
Chip selects, register address, strobes, the 16-bit indicator, write data and the IRQ lines are all due exactly one clock edge after the host inputs that cause them. The read data and lane enables are combinational from the drive inputs, but they are gated by the registered read strobe, so they are due in the same cycle as that strobe. The bench changes inputs on the falling edge, waits for one rising edge, and samples one time unit later. Every expected value therefore belongs to the inputs that were applied just before that edge. The sweep covers two 32-address windows around both register blocks, under every combination of address enable, command line and drive presence, and every IRQ selection with the interrupt both high and low.

// File: rtl/isaide_pkg.sv
package isaide_pkg;

  localparam int unsigned REG_ADDR_W = 3;

  // Strobe bundle handed from control to datapath (all active high).
  typedef struct packed {
    logic                  cs0;
    logic                  cs1;
    logic [REG_ADDR_W-1:0] da;
    logic                  rd;
    logic                  wr;
    logic                  wide;
  } ideStb_t;

  localparam ideStb_t STB_IDLE = '{cs0: 1'b0, cs1: 1'b0, da: '0,
                                   rd: 1'b0, wr: 1'b0, wide: 1'b0};

endpackage

// File: rtl/isaide_ctrl.sv
module isaide_ctrl
  import isaide_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 10,
  parameter logic [ADDR_W-1:0]  CMD_BASE  = 10'h1F0,
  parameter logic [ADDR_W-1:0]  CTRL_ADDR = 10'h3F6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] isaAddr,
  input  logic              isaAen,
  input  logic              isaIorN,
  input  logic              isaIowN,
  output ideStb_t           stb
);

  localparam int unsigned BLK_HI = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] UNCLAIMED = CTRL_ADDR + 1'b1;

  logic    cmdRd, cmdWr, access, cmdHit, ctrlHit, anyHit;
  ideStb_t stbNxt;

  always_comb begin
    cmdRd   = !isaIorN && isaIowN;
    cmdWr   = !isaIowN && isaIorN;
    access  = !isaAen && (cmdRd || cmdWr);
    cmdHit  = isaAddr[BLK_HI:REG_ADDR_W] == CMD_BASE[BLK_HI:REG_ADDR_W];
    ctrlHit = isaAddr == CTRL_ADDR;
    anyHit  = access && (cmdHit || ctrlHit);

    stbNxt      = STB_IDLE;
    stbNxt.cs0  = access && cmdHit;
    stbNxt.cs1  = access && ctrlHit;
    stbNxt.da   = anyHit ? isaAddr[REG_ADDR_W-1:0] : '0;
    stbNxt.rd   = anyHit && cmdRd;
    stbNxt.wr   = anyHit && cmdWr;
    stbNxt.wide = access && cmdHit && (isaAddr[REG_ADDR_W-1:0] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) stb <= STB_IDLE;
    else       stb <= stbNxt;
  end

  // R4
  aen_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(isaAen) |-> !stb.cs0 && !stb.cs1 && !stb.rd && !stb.wr && !stb.wide);

  // R5
  unclaimed_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(isaAddr) == UNCLAIMED) |-> !stb.cs0 && !stb.cs1);

  // R2
  cs_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.cs0, stb.cs1}));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.rd && stb.wr) && ((stb.rd || stb.wr) == (stb.cs0 || stb.cs1)));

  // R6
  both_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(isaIorN) && !$past(isaIowN)) |-> !stb.rd && !stb.wr);

  // R7
  wide_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wide |-> stb.cs0 && (stb.da == '0));

endmodule

// File: rtl/isaide_dpath.sv
module isaide_dpath
  import isaide_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned NUM_IRQ = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ideStb_t                    stb,
  input  logic [DATA_W-1:0]          isaDataIn,
  output logic [DATA_W-1:0]          isaDataOut,
  output logic [DATA_W/8-1:0]        isaLaneOe,
  input  logic [DATA_W-1:0]          ideDataIn,
  output logic [DATA_W-1:0]          ideDataOut,
  output logic                       ideDataOe,
  input  logic                       drivePresent,
  input  logic                       ideIntrq,
  input  logic [$clog2(NUM_IRQ)-1:0] irqSel,
  output logic [NUM_IRQ-1:0]         isaIrq
);

  localparam int unsigned LANES   = DATA_W / 8;
  localparam int unsigned BUSY_IX = 7;
  localparam logic [DATA_W-1:0] FLOAT_WORD = ~(DATA_W'(1) << BUSY_IX);

  logic [DATA_W-1:0] wrData;

  // Host write data is captured on the same edge that registers the strobes.
  always_ff @(posedge clk) begin
    if (!rstN) wrData <= '0;
    else       wrData <= isaDataIn;
  end

  assign ideDataOut = wrData;
  assign ideDataOe  = stb.wr;

  // Read steering: the drive's word, or the pulled-down floating value.
  assign isaDataOut = !stb.rd      ? '0 :
                      drivePresent ? ideDataIn : FLOAT_WORD;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == 0) begin : g_low
      assign isaLaneOe[l] = stb.rd;
    end else begin : g_high
      assign isaLaneOe[l] = stb.rd && stb.wide;
    end
  end

  for (genvar q = 0; q < NUM_IRQ; q++) begin : g_irq
    always_ff @(posedge clk) begin
      if (!rstN) isaIrq[q] <= 1'b0;
      else       isaIrq[q] <= ideIntrq && (irqSel == q);
    end
  end

  // R10
  float_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rd && !drivePresent) |-> !isaDataOut[BUSY_IX]);

  // R8
  wr_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    ideDataOe |-> ideDataOut == $past(isaDataIn));

  // R11
  irq_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(isaIrq));

  // R11
  irq_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> isaIrq[$past(irqSel)] == $past(ideIntrq));

endmodule

// File: rtl/isa_ide_adapter.sv
module isa_ide_adapter
  import isaide_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [9:0]  isaAddr,
  input  logic        isaAen,
  input  logic        isaIorN,
  input  logic        isaIowN,
  input  logic [15:0] isaDataIn,
  output logic [15:0] isaDataOut,
  output logic [1:0]  isaLaneOe,
  output logic        isaIocs16N,
  output logic [3:0]  isaIrq,
  input  logic [1:0]  irqSel,
  output logic        ideCs0N,
  output logic        ideCs1N,
  output logic [2:0]  ideDa,
  output logic        ideDiorN,
  output logic        ideDiowN,
  output logic [15:0] ideDataOut,
  output logic        ideDataOe,
  input  logic [15:0] ideDataIn,
  input  logic        drivePresent,
  input  logic        ideIntrq
);

  ideStb_t stb;

  isaide_ctrl #(
    .ADDR_W(10), .CMD_BASE(10'h1F0), .CTRL_ADDR(10'h3F6)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .isaAddr(isaAddr), .isaAen(isaAen),
    .isaIorN(isaIorN), .isaIowN(isaIowN), .stb(stb)
  );

  isaide_dpath #(
    .DATA_W(16), .NUM_IRQ(4)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .isaDataIn(isaDataIn), .isaDataOut(isaDataOut), .isaLaneOe(isaLaneOe),
    .ideDataIn(ideDataIn), .ideDataOut(ideDataOut), .ideDataOe(ideDataOe),
    .drivePresent(drivePresent), .ideIntrq(ideIntrq), .irqSel(irqSel),
    .isaIrq(isaIrq)
  );

  assign ideCs0N    = !stb.cs0;
  assign ideCs1N    = !stb.cs1;
  assign ideDa      = stb.da;
  assign ideDiorN   = !stb.rd;
  assign ideDiowN   = !stb.wr;
  assign isaIocs16N = !stb.wide;

endmodule

// File: tb/isa_ide_adapter_tb.sv
module isa_ide_adapter_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN;
  logic [9:0]  isaAddr;
  logic        isaAen, isaIorN, isaIowN;
  logic [15:0] isaDataIn, isaDataOut, ideDataOut, ideDataIn;
  logic [1:0]  isaLaneOe, irqSel;
  logic        isaIocs16N;
  logic [3:0]  isaIrq;
  logic        ideCs0N, ideCs1N, ideDiorN, ideDiowN, ideDataOe;
  logic [2:0]  ideDa;
  logic        drivePresent, ideIntrq;

  int nRun  = 0;
  int nFail = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isa_ide_adapter dut_i (
    .clk(clk), .rstN(rstN), .isaAddr(isaAddr), .isaAen(isaAen),
    .isaIorN(isaIorN), .isaIowN(isaIowN), .isaDataIn(isaDataIn),
    .isaDataOut(isaDataOut), .isaLaneOe(isaLaneOe), .isaIocs16N(isaIocs16N),
    .isaIrq(isaIrq), .irqSel(irqSel), .ideCs0N(ideCs0N), .ideCs1N(ideCs1N),
    .ideDa(ideDa), .ideDiorN(ideDiorN), .ideDiowN(ideDiowN),
    .ideDataOut(ideDataOut), .ideDataOe(ideDataOe), .ideDataIn(ideDataIn),
    .drivePresent(drivePresent), .ideIntrq(ideIntrq)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [9:0] a, input logic aen, input int cmd,
                       input logic dp);
    @(negedge clk);
    isaAddr      = a;
    isaAen       = aen;
    isaIorN      = !(cmd == 1 || cmd == 3);
    isaIowN      = !(cmd == 2 || cmd == 3);
    isaDataIn    = 16'hA500 ^ {6'd0, a};
    ideDataIn    = 16'hC381 ^ {4'd0, a, 2'd0};
    drivePresent = dp;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; isaAddr = 10'h1F0; isaAen = 1'b0; isaIorN = 1'b0;
    isaIowN = 1'b1; isaDataIn = '0; ideDataIn = '0; drivePresent = 1'b1;
    ideIntrq = 1'b1; irqSel = 2'd2;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs idle while reset held, despite an active access
    chk("R1 cs0", {31'd0, ideCs0N}, 1);
    chk("R1 cs1", {31'd0, ideCs1N}, 1);
    chk("R1 strobes", {30'd0, ideDiorN, ideDiowN}, 3);
    chk("R1 iocs16", {31'd0, isaIocs16N}, 1);
    chk("R1 da", {29'd0, ideDa}, 0);
    chk("R1 lanes", {30'd0, isaLaneOe}, 0);
    chk("R1 ideOe", {31'd0, ideDataOe}, 0);
    chk("R1 irq", {28'd0, isaIrq}, 0);
    @(negedge clk);
    rstN = 1'b1;

    for (int w = 0; w < 2; w++) begin
      for (int off = 0; off < 32; off++) begin
        for (int aenI = 0; aenI < 2; aenI++) begin
          for (int cmd = 0; cmd < 4; cmd++) begin
            for (int dpI = 0; dpI < 2; dpI++) begin
              logic [9:0]  a;
              logic        rdA, wrA, acc, eCs0, eCs1, hit, wide;
              logic [15:0] eRd;
              a = (w == 0 ? 10'h1E0 : 10'h3E0) + 10'(off);
              drive(a, aenI[0], cmd, dpI[0]);
              rdA  = (cmd == 1);
              wrA  = (cmd == 2);
              acc  = !aenI[0] && (rdA || wrA);
              eCs0 = acc && a >= 10'h1F0 && a <= 10'h1F7;
              eCs1 = acc && a == 10'h3F6;
              hit  = eCs0 || eCs1;
              wide = eCs0 && a == 10'h1F0;
              eRd  = !(hit && rdA) ? 16'h0000 :
                     dpI[0] ? (16'hC381 ^ {4'd0, a, 2'd0}) : 16'hFF7F;
              // R2 R3 R4 R5: selects and register address
              chk(eCs1 ? "R3 cs1" : (aenI[0] ? "R4 cs1" : "R5 cs1"),
                  {31'd0, ideCs1N}, {31'd0, !eCs1});
              chk(eCs0 ? "R2 cs0" : (aenI[0] ? "R4 cs0" : "R5 cs0"),
                  {31'd0, ideCs0N}, {31'd0, !eCs0});
              chk(eCs1 ? "R3 da" : "R2 da", {29'd0, ideDa},
                  {29'd0, hit ? a[2:0] : 3'd0});
              // R6: strobes, with both commands treated as no access
              chk("R6 dior", {31'd0, ideDiorN}, {31'd0, !(hit && rdA)});
              chk("R6 diow", {31'd0, ideDiowN}, {31'd0, !(hit && wrA)});
              // R7: 16-bit only at the data port
              chk("R7 iocs16", {31'd0, isaIocs16N}, {31'd0, !wide});
              chk("R7 lanes", {30'd0, isaLaneOe},
                  {30'd0, wide && rdA, hit && rdA});
              // R8: write path
              chk("R8 ideOe", {31'd0, ideDataOe}, {31'd0, hit && wrA});
              if (hit && wrA)
                chk("R8 wdata", {16'd0, ideDataOut},
                    {16'd0, 16'hA500 ^ {6'd0, a}});
              // R9 R10: read path, drive or pulled-down floating value
              chk(dpI[0] ? "R9 rdata" : "R10 rdata", {16'd0, isaDataOut},
                  {16'd0, eRd});
            end
          end
        end
      end
    end

    // R11: interrupt routing for every select
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 2; v++) begin
        @(negedge clk);
        irqSel   = 2'(s);
        ideIntrq = v[0];
        @(posedge clk);
        #1;
        chk("R11 irq", {28'd0, isaIrq}, v[0] ? (32'd1 << s) : 32'd0);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule